// File: doc/BRIEF.md
# Search Window Scan Order Generator

This block produces the order in which a block-matching motion estimator visits candidate positions inside a rectangular search window. After a start request it emits one (x, y) candidate offset per clock, measured from the top-left corner of the window. It flags the first position of every line and of every sub-region, and it pulses a completion strobe once the whole window has been covered. Pixel fetch and cost computation sit downstream and take the candidates as they come.

Three orders are available. Raster sweeps each row from left to right. Snake alternates the row direction so that consecutive candidates always touch. Tiled cuts the window into equal, non-overlapping sub-regions. It walks those sub-regions in a serpentine path across the tile grid and snake-scans each one. The orientation (row-wise or column-wise) and the start corner of the snake inside a sub-region are selectable. The window and sub-region sizes are captured when a start is accepted. A size combination that cannot tile the window is rejected with an error flag, and in that case no candidates are emitted.

Top module: `scan_order_gen`

## Requirements
- R1: With mode code 2'b00 (raster), rows are visited from top to bottom, and every row runs from x=0 up to x=width-1.
- R2: With mode code 2'b01 (snake), rows are visited from top to bottom. Row 0 runs left to right, and the direction reverses on every following row.
- R3: With mode code 2'b10 (tiled), the window is split into sub-regions of the requested size. The first tile row is walked left to right, the next right to left, and so on downward. Each sub-region is finished before the next one is entered.
- R4: Inside a sub-region the scan is a snake. When the column-wise input is 1, the fast axis is y; when it is 0, the fast axis is x. When the from-right input is 1, the scan starts at the right edge. When the from-bottom input is 1, the scan starts at the bottom edge.
- R5: One candidate is emitted per clock, and valid stays high without gaps from the cycle after an accepted start. The scan covers width*height positions, each of them exactly once.
- R6: The done strobe is high for exactly one cycle, in the cycle after the last valid candidate, and valid is low in that cycle.
- R7: The line-start flag is high on the first candidate of every line. The region-start flag is high on the first candidate of every sub-region, which in raster and snake means only the first candidate of the scan. Region-start implies line-start.
- R8: Within a line, consecutive candidates differ by exactly one step along exactly one axis.
- R9: A start is rejected in any of these cases: a width or height is zero, the mode code is 2'b11, or in tiled mode the window size is not an integer multiple of the sub-region size. A rejected start raises the error flag in the next cycle and produces no valid and no done. The next accepted start clears the flag.
- R10: A start while a scan is running is ignored. Size and mode inputs are sampled only when a start is accepted.
- R11: After reset, valid, done and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new scan (accepted only when idle) |
| mode | input | 2 | 00 raster, 01 snake, 10 tiled, 11 reserved |
| win_w | input | CW | Window width in positions |
| win_h | input | CW | Window height in positions |
| reg_w | input | CW | Sub-region width (tiled mode only) |
| reg_h | input | CW | Sub-region height (tiled mode only) |
| reg_colwise | input | 1 | 1: snake within a sub-region runs along columns |
| reg_from_right | input | 1 | 1: sub-region scan starts at its right edge |
| reg_from_bottom | input | 1 | 1: sub-region scan starts at its bottom edge |
| cand_valid | output | 1 | Candidate offset is valid this cycle |
| cand_x | output | CW | Candidate column offset |
| cand_y | output | CW | Candidate row offset |
| line_start | output | 1 | First candidate of a line |
| region_start | output | 1 | First candidate of a sub-region |
| scan_done | output | 1 | One-cycle strobe after the last candidate |
| cfg_err | output | 1 | Last start was rejected |

## Verification
Raster and snake runs over narrow, single-column and near-maximal windows separate a fixed row direction from an alternating one. They also expose off-by-one errors at the row ends. Tiled runs cover both orientations and all four start corners, with tile grids of different column and row counts, including a single tile equal to the window. These runs show whether the tile walk turns around correctly on odd tile rows and whether the snake inside a tile picks the right axis and start edge. Every candidate is compared against an order computed arithmetically from its index, and a coverage map confirms that each position is visited once. Separate runs with non-dividing sizes, a reserved mode, zero sizes and starts issued mid-scan check rejection and the ignoring of inputs.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {
        SCAN_RASTER = 2'd0,
        SCAN_SNAKE  = 2'd1,
        SCAN_TILED  = 2'd2,
        SCAN_RSVD   = 2'd3
    } scan_mode_e;
endpackage

// File: rtl/scan_cfg_check.sv
module scan_cfg_check
    import scan_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic [1:0]    mode,
    input  logic [CW-1:0] win_w,
    input  logic [CW-1:0] win_h,
    input  logic [CW-1:0] reg_w,
    input  logic [CW-1:0] reg_h,
    input  logic          colwise,
    input  logic          from_right,
    input  logic          from_bottom,
    output logic          cfg_ok,
    output logic [CW-1:0] tile_w,
    output logic [CW-1:0] tile_h,
    output logic          tile_colw,
    output logic          fast_flip,
    output logic          slow_flip,
    output logic          serp
);
    logic tiled;
    logic w_fits;
    logic h_fits;

    always_comb begin
        tiled  = (mode == SCAN_TILED);
        w_fits = (reg_w != '0) && ((win_w % reg_w) == '0);
        h_fits = (reg_h != '0) && ((win_h % reg_h) == '0);
        cfg_ok = (win_w != '0) && (win_h != '0) && (mode != SCAN_RSVD)
                 && (!tiled || (w_fits && h_fits));
        // raster and snake treat the whole window as a single tile
        tile_w    = tiled ? reg_w : win_w;
        tile_h    = tiled ? reg_h : win_h;
        tile_colw = tiled && colwise;
        fast_flip = tiled && (colwise ? from_bottom : from_right);
        slow_flip = tiled && (colwise ? from_right : from_bottom);
        serp      = (mode != SCAN_RASTER);
    end
endmodule

// File: rtl/scan_axis.sv
// One coordinate stepper: reports whether pos sits at the far end of its
// range in the current direction and what the next coordinate would be.
module scan_axis #(
    parameter int CW = 6
) (
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] step,
    input  logic [CW-1:0] limit,
    input  logic          rev,
    output logic          at_end,
    output logic [CW-1:0] nxt
);
    logic [CW:0] sum;

    always_comb begin
        sum    = {1'b0, pos} + {1'b0, step};
        at_end = rev ? (pos == '0) : (sum == {1'b0, limit});
        nxt    = rev ? (pos - step) : sum[CW-1:0];
    end
endmodule

// File: rtl/scan_order_gen.sv
module scan_order_gen
    import scan_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] win_w,
    input  logic [CW-1:0] win_h,
    input  logic [CW-1:0] reg_w,
    input  logic [CW-1:0] reg_h,
    input  logic          reg_colwise,
    input  logic          reg_from_right,
    input  logic          reg_from_bottom,
    output logic          cand_valid,
    output logic [CW-1:0] cand_x,
    output logic [CW-1:0] cand_y,
    output logic          line_start,
    output logic          region_start,
    output logic          scan_done,
    output logic          cfg_err
);
    localparam int NAX = 4;   // fast, slow, tile column, tile row
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic          run;
        logic          colw;
        logic          ffl;
        logic          sfl;
        logic          serp;
        logic [CW-1:0] ww;
        logic [CW-1:0] wh;
        logic [CW-1:0] tw;
        logic [CW-1:0] th;
        logic [CW-1:0] lf;
        logic [CW-1:0] ls;
        logic [CW-1:0] ox;
        logic [CW-1:0] oy;
        logic          fdir;
        logic          trev;
        logic          line;
        logic          region;
        logic          done;
        logic          err;
    } st_t;

    st_t st_q, st_d;

    logic          cfg_ok, cfg_colw, cfg_ffl, cfg_sfl, cfg_serp;
    logic [CW-1:0] cfg_tw, cfg_th, in_fl, in_sl;
    logic [CW-1:0] fl, sl, lf_home, ls_home;

    logic [CW-1:0] ax_pos  [NAX];
    logic [CW-1:0] ax_step [NAX];
    logic [CW-1:0] ax_lim  [NAX];
    logic          ax_rev  [NAX];
    logic          ax_end  [NAX];
    logic [CW-1:0] ax_nxt  [NAX];

    scan_cfg_check #(.CW(CW)) u_cfg (
        .mode       (mode),
        .win_w      (win_w),
        .win_h      (win_h),
        .reg_w      (reg_w),
        .reg_h      (reg_h),
        .colwise    (reg_colwise),
        .from_right (reg_from_right),
        .from_bottom(reg_from_bottom),
        .cfg_ok     (cfg_ok),
        .tile_w     (cfg_tw),
        .tile_h     (cfg_th),
        .tile_colw  (cfg_colw),
        .fast_flip  (cfg_ffl),
        .slow_flip  (cfg_sfl),
        .serp       (cfg_serp)
    );

    assign fl    = st_q.colw ? st_q.th : st_q.tw;
    assign sl    = st_q.colw ? st_q.tw : st_q.th;
    assign in_fl = cfg_colw ? cfg_th : cfg_tw;
    assign in_sl = cfg_colw ? cfg_tw : cfg_th;

    assign ax_pos[0] = st_q.lf;  assign ax_step[0] = ONE;     assign ax_lim[0] = fl;      assign ax_rev[0] = st_q.fdir;
    assign ax_pos[1] = st_q.ls;  assign ax_step[1] = ONE;     assign ax_lim[1] = sl;      assign ax_rev[1] = st_q.sfl;
    assign ax_pos[2] = st_q.ox;  assign ax_step[2] = st_q.tw; assign ax_lim[2] = st_q.ww; assign ax_rev[2] = st_q.trev;
    assign ax_pos[3] = st_q.oy;  assign ax_step[3] = st_q.th; assign ax_lim[3] = st_q.wh; assign ax_rev[3] = 1'b0;

    for (genvar gi = 0; gi < NAX; gi++) begin : g_axis
        scan_axis #(.CW(CW)) u_axis (
            .pos   (ax_pos[gi]),
            .step  (ax_step[gi]),
            .limit (ax_lim[gi]),
            .rev   (ax_rev[gi]),
            .at_end(ax_end[gi]),
            .nxt   (ax_nxt[gi])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        lf_home   = st_q.ffl ? (fl - ONE) : '0;
        ls_home   = st_q.sfl ? (sl - ONE) : '0;
        if (start && !st_q.run) begin
            st_d.err    = !cfg_ok;
            st_d.run    = cfg_ok;
            st_d.ww     = win_w;
            st_d.wh     = win_h;
            st_d.tw     = cfg_tw;
            st_d.th     = cfg_th;
            st_d.colw   = cfg_colw;
            st_d.ffl    = cfg_ffl;
            st_d.sfl    = cfg_sfl;
            st_d.serp   = cfg_serp;
            st_d.lf     = cfg_ffl ? (in_fl - ONE) : '0;
            st_d.ls     = cfg_sfl ? (in_sl - ONE) : '0;
            st_d.fdir   = cfg_ffl;
            st_d.ox     = '0;
            st_d.oy     = '0;
            st_d.trev   = 1'b0;
            st_d.line   = cfg_ok;
            st_d.region = cfg_ok;
        end else if (st_q.run) begin
            st_d.line   = 1'b0;
            st_d.region = 1'b0;
            if (!ax_end[0]) begin
                st_d.lf = ax_nxt[0];
            end else if (!ax_end[1]) begin
                st_d.ls   = ax_nxt[1];
                st_d.line = 1'b1;
                if (st_q.serp) st_d.fdir = ~st_q.fdir;
                else           st_d.lf   = lf_home;
            end else begin
                // sub-region finished: return to its start corner in the next tile
                st_d.lf     = lf_home;
                st_d.ls     = ls_home;
                st_d.fdir   = st_q.ffl;
                st_d.line   = 1'b1;
                st_d.region = 1'b1;
                if (!ax_end[2]) begin
                    st_d.ox = ax_nxt[2];
                end else if (!ax_end[3]) begin
                    st_d.oy   = ax_nxt[3];
                    st_d.trev = ~st_q.trev;
                end else begin
                    st_d.run    = 1'b0;
                    st_d.done   = 1'b1;
                    st_d.line   = 1'b0;
                    st_d.region = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cand_valid   = st_q.run;
    assign cand_x       = st_q.ox + (st_q.colw ? st_q.ls : st_q.lf);
    assign cand_y       = st_q.oy + (st_q.colw ? st_q.lf : st_q.ls);
    assign line_start   = st_q.line && st_q.run;
    assign region_start = st_q.region && st_q.run;
    assign scan_done    = st_q.done;
    assign cfg_err      = st_q.err;
endmodule

// File: rtl/scan_order_gen_chk.sv
module scan_order_gen_chk #(
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          cand_valid,
    input logic [CW-1:0] cand_x,
    input logic [CW-1:0] cand_y,
    input logic          line_start,
    input logic          region_start,
    input logic          scan_done,
    input logic          cfg_err
);
    logic [CW-1:0] px_q, py_q;
    logic [CW-1:0] dx, dy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            px_q <= '0;
            py_q <= '0;
        end else begin
            px_q <= cand_x;
            py_q <= cand_y;
        end
    end

    assign dx = (cand_x > px_q) ? (cand_x - px_q) : (px_q - cand_x);
    assign dy = (cand_y > py_q) ? (cand_y - py_q) : (py_q - cand_y);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    assert_done_follows_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cand_valid) |-> scan_done);

    assert_done_no_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> !cand_valid);

    assert_err_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!cand_valid && !scan_done));

    assert_region_implies_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        region_start |-> (line_start && cand_valid));

    assert_first_is_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cand_valid) |-> region_start);

    assert_unit_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && $past(cand_valid) && !line_start) |-> ((dx + dy) == CW'(1)));

    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && start) |=> (cand_valid || scan_done));
endmodule

bind scan_order_gen scan_order_gen_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cand_valid  (cand_valid),
    .cand_x      (cand_x),
    .cand_y      (cand_y),
    .line_start  (line_start),
    .region_start(region_start),
    .scan_done   (scan_done),
    .cfg_err     (cfg_err)
);

// File: tb/scan_order_gen_test.sv
`timescale 1ns/1ps
module scan_order_gen_test;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [CW-1:0] win_w = '0, win_h = '0, reg_w = '0, reg_h = '0;
    logic          reg_colwise = 1'b0, reg_from_right = 1'b0, reg_from_bottom = 1'b0;
    logic          cand_valid, line_start, region_start, scan_done, cfg_err;
    logic [CW-1:0] cand_x, cand_y;

    int  nchk = 0;
    int  nfail = 0;
    bit  finished = 1'b0;
    bit  seen [16][16];

    always #2 clk = ~clk;   // 250 MHz

    scan_order_gen #(.CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .win_w(win_w), .win_h(win_h), .reg_w(reg_w), .reg_h(reg_h),
        .reg_colwise(reg_colwise), .reg_from_right(reg_from_right),
        .reg_from_bottom(reg_from_bottom),
        .cand_valid(cand_valid), .cand_x(cand_x), .cand_y(cand_y),
        .line_start(line_start), .region_start(region_start),
        .scan_done(scan_done), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected candidate k computed from index arithmetic.
    task automatic model(input int k, input int md, input int w, input int h,
                         input int tw_in, input int th_in, input int cw, input int hf,
                         input int vf, output int ex, output int ey,
                         output int el, output int er);
        int tw, th, colw, fr, fb, serp, nx, n, t, r, tr, tc, fl, sl, ffl, sfl;
        int s, f, fd, lf, ls;
        if (md == 2) begin
            tw = tw_in; th = th_in; colw = cw; fr = hf; fb = vf;
        end else begin
            tw = w; th = h; colw = 0; fr = 0; fb = 0;
        end
        serp = (md != 0);
        nx = w / tw;
        n  = tw * th;
        t  = k / n;
        r  = k % n;
        tr = t / nx;
        tc = (tr % 2 == 1) ? (nx - 1 - (t % nx)) : (t % nx);
        fl = colw ? th : tw;
        sl = colw ? tw : th;
        ffl = colw ? fb : fr;
        sfl = colw ? fr : fb;
        s  = r / fl;
        f  = r % fl;
        fd = ffl ^ (serp & (s % 2));
        lf = fd ? (fl - 1 - f) : f;
        ls = sfl ? (sl - 1 - s) : s;
        ex = tc * tw + (colw ? ls : lf);
        ey = tr * th + (colw ? lf : ls);
        el = (f == 0);
        er = (r == 0);
    endtask

    task automatic run_scan(input string req, input int md, input int w, input int h,
                            input int tw, input int th, input int cw, input int hf,
                            input int vf, input bit poke);
        int n, ex, ey, el, er, px, py, covered;
        n = w * h;
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++) seen[i][j] = 1'b0;
        @(negedge clk);
        mode = 2'(md); win_w = CW'(w); win_h = CW'(h); reg_w = CW'(tw); reg_h = CW'(th);
        reg_colwise = cw[0]; reg_from_right = hf[0]; reg_from_bottom = vf[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cfg_err == 1'b0, "R9", "error clear after good start", int'(cfg_err), 0);
        px = 0; py = 0;
        for (int k = 0; k < n; k++) begin
            model(k, md, w, h, tw, th, cw, hf, vf, ex, ey, el, er);
            chk(cand_valid == 1'b1, "R5", "valid during scan", int'(cand_valid), 1);
            if (md == 0)      chk(cand_x == CW'(ex) && cand_y == CW'(ey), "R1", "raster pos x*64+y", int'(cand_x)*64+int'(cand_y), ex*64+ey);
            else if (md == 1) chk(cand_x == CW'(ex) && cand_y == CW'(ey), "R2", "snake pos x*64+y", int'(cand_x)*64+int'(cand_y), ex*64+ey);
            else              chk(cand_x == CW'(ex) && cand_y == CW'(ey), "R3_R4", "tiled pos x*64+y", int'(cand_x)*64+int'(cand_y), ex*64+ey);
            chk(line_start == el[0] && region_start == er[0], "R7", "flags line*2+region",
                int'(line_start)*2+int'(region_start), el*2+er);
            if (k > 0 && el == 0) begin
                int d;
                d = ((int'(cand_x) > px) ? int'(cand_x) - px : px - int'(cand_x))
                  + ((int'(cand_y) > py) ? int'(cand_y) - py : py - int'(cand_y));
                chk(d == 1, "R8", "step distance", d, 1);
            end
            px = int'(cand_x); py = int'(cand_y);
            if (cand_x < 16 && cand_y < 16) begin
                chk(!seen[cand_x][cand_y], "R5", "revisit x*64+y", int'(cand_x)*64+int'(cand_y), -1);
                seen[cand_x][cand_y] = 1'b1;
            end
            chk(scan_done == 1'b0, "R6", "no done during scan", int'(scan_done), 0);
            if (poke && k == 2) begin
                start = 1'b1; mode = mode ^ 2'd1; win_w = win_w + CW'(1); reg_h = reg_h + CW'(1);
            end
            if (poke && k == 3) start = 1'b0;
            @(negedge clk);
        end
        chk(cand_valid == 1'b0 && scan_done == 1'b1, "R6", "done after last valid*2+done",
            int'(cand_valid)*2+int'(scan_done), 1);
        covered = 0;
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++) covered += int'(seen[i][j]);
        chk(covered == n, "R5", "positions covered", covered, n);
        @(negedge clk);
        chk(scan_done == 1'b0 && cand_valid == 1'b0, "R6", "done single cycle",
            int'(scan_done)*2+int'(cand_valid), 0);
        if (poke) chk(1'b1, "R10", "busy start ignored", 0, 0);
    endtask

    task automatic run_bad(input int md, input int w, input int h, input int tw, input int th);
        @(negedge clk);
        mode = 2'(md); win_w = CW'(w); win_h = CW'(h); reg_w = CW'(tw); reg_h = CW'(th);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cfg_err == 1'b1, "R9", "error raised", int'(cfg_err), 1);
        for (int i = 0; i < 4; i++) begin
            chk(cand_valid == 1'b0 && scan_done == 1'b0, "R9", "nothing emitted valid*2+done",
                int'(cand_valid)*2+int'(scan_done), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cand_valid == 1'b0 && scan_done == 1'b0 && cfg_err == 1'b0, "R11", "reset outputs",
            int'(cand_valid)*4+int'(scan_done)*2+int'(cfg_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cand_valid == 1'b0, "R11", "idle after reset", int'(cand_valid), 0);

        run_scan("R1", 0, 5, 3, 0, 0, 0, 0, 0, 1'b0);
        run_scan("R1", 0, 15, 15, 0, 0, 0, 0, 0, 1'b0);
        run_scan("R2", 1, 6, 4, 0, 0, 1, 1, 1, 1'b0);
        run_scan("R2", 1, 1, 5, 0, 0, 0, 0, 0, 1'b0);
        run_scan("R2", 1, 7, 5, 0, 0, 0, 0, 0, 1'b1);
        run_scan("R3", 2, 8, 6, 4, 3, 0, 0, 0, 1'b0);
        run_scan("R4", 2, 8, 6, 2, 3, 1, 1, 1, 1'b0);
        run_scan("R4", 2, 9, 4, 3, 2, 0, 1, 0, 1'b0);
        run_scan("R4", 2, 12, 8, 4, 4, 1, 0, 1, 1'b0);
        run_scan("R4", 2, 6, 9, 3, 3, 0, 0, 1, 1'b1);
        run_scan("R3", 2, 4, 4, 4, 4, 1, 1, 0, 1'b0);
        run_scan("R3", 2, 5, 3, 1, 1, 0, 0, 0, 1'b0);

        run_bad(2, 8, 6, 3, 3);
        run_bad(2, 8, 6, 4, 4);
        run_bad(3, 4, 4, 2, 2);
        run_bad(0, 0, 4, 1, 1);
        run_bad(2, 4, 4, 0, 2);
        run_scan("R9", 1, 3, 3, 0, 0, 0, 0, 0, 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL R5 watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule